// File: doc/BRIEF.md
# Byte-Wide Flash Command and Embedded-Algorithm Controller

This block sits behind the bus of a byte-wide NOR-style flash array. Writes on the bus are decoded into commands. Each command opens with a pair of unlock writes and then carries a command code. The controller then runs the internal program and erase algorithms by itself against a parameterized on-chip byte array. While an algorithm runs, a read cycle returns a status byte instead of array data, so software can tell when the work is finished by polling.

An erase can select any mix of sectors. A second command selects the whole chip. A running erase can be paused so that software can read sectors outside the erase set or program bytes in them, and the erase then continues from the point where it stopped. A per-sector protect input blocks every program and erase that is aimed at a protected sector.

Top module: `flash_ctrl`

## Requirements
- R1: After reset the controller is in read mode and every byte of the array reads 8'hFF.
- R2: The unlock writes 8'hAA to address 555h and 8'h55 to address 2AAh, followed by 8'hA0 to 555h and then a data write, program the byte at that write's address. Only the address bits that exist are compared. The stored byte becomes the old value ANDed with the new data, so programming can only clear bits.
- R3: A write that breaks an unlock or command sequence returns the decoder to read mode. A write of 8'hF0 while a sequence is open also returns it to read mode. In both cases the array is left unchanged.
- R4: While a program runs, status bit 7 reads as the complement of bit 7 of the data being programmed. Once the program completes, a read of that address returns the stored byte.
- R5: Status bit 6 changes on every read while a program or an erase is running. Reads while idle return stable array data.
- R6: The unlock writes, then 8'h80, then a second unlock pair, then 8'h30 written to one address in each chosen sector, start an erase of those sectors. Further 8'h30 writes within WIN_CYC cycles of each other add sectors. Every chosen sector then reads 8'hFF, and all other sectors keep their contents.
- R7: Ending the erase sequence with 8'h10 to 555h erases every sector that is not protected.
- R8: A program or erase aimed at a sector whose protect bit is 1 is ignored, and that sector keeps its contents.
- R9: During a running erase, status bit 7 reads 0. Status bit 2 changes on successive reads only when the address read lies in the erase set.
- R10: The write 8'hB0 to any address suspends a running erase. While the erase is suspended, reads of sectors outside the erase set return array data. Reads inside the set return a status byte with bit 7 = 1, bit 6 stable and bit 2 changing.
- R11: While an erase is suspended, a program to a sector outside the erase set completes normally, and a program to a sector inside the set is ignored.
- R12: The write 8'h30 while suspended resumes the erase, which completes with the same outcome as an erase that was never paused.
- R13: While a program or erase is running, every write other than the suspend code is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low; a write is one clock with ce_n and we_n low |
| oe_n | input | 1 | Read strobe, active low; a read is one clock with ce_n and oe_n low and we_n high |
| addr | input | ADDR_W | Byte address; the top SECT_BITS bits select the sector |
| wdata | input | 8 | Write data or command code |
| rdata | output | 8 | Array byte or status byte, valid the cycle after the read clock |
| sect_prot | input | 2**SECT_BITS | Protect bit per sector |

## Verification
The hardest state to reach is a suspended erase with a program inside it. The erase has to be started, left running long enough to be mid-sector, and then paused. A full program must then run and finish while the erase set is frozen. The bench reaches this state by counting cycles from the last sector-select write past the collection window before it issues the suspend. It then programs one byte outside the set and attempts one inside it, and checks that the second attempt leaves the controller idle in suspension. After the resume it confirms by a sweep of the full array that the paused erase finished cleanly.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [3:0] {
    A_IDLE, A_SUSP,
    A_PG_RD, A_PG_CAP, A_PG_WAIT, A_PG_WR, A_PG_VRD, A_PG_VCHK,
    A_ER_SEL, A_PRE_RD, A_PRE_CHK, A_ER_PULSE, A_ER_WR, A_EV_RD, A_EV_CHK
  } algo_st_t;

  typedef enum logic [2:0] {
    D_RD, D_U1, D_U2, D_PG, D_E1, D_E2, D_E3, D_COL
  } dec_st_t;

  localparam logic [7:0] CODE_UNLK1 = 8'hAA;
  localparam logic [7:0] CODE_UNLK2 = 8'h55;
  localparam logic [7:0] CODE_PROG  = 8'hA0;
  localparam logic [7:0] CODE_ERASE = 8'h80;
  localparam logic [7:0] CODE_SECT  = 8'h30;
  localparam logic [7:0] CODE_CHIP  = 8'h10;
  localparam logic [7:0] CODE_SUSP  = 8'hB0;
  localparam logic [7:0] CODE_RST   = 8'hF0;
  localparam logic [7:0] BYTE_ERASED = 8'hFF;
  localparam logic [7:0] BYTE_ZERO   = 8'h00;
  localparam logic [10:0] UNLK_A1 = 11'h555;
  localparam logic [10:0] UNLK_A2 = 11'h2AA;
endpackage

// File: rtl/flash_array.sv
module flash_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_q,
  input  logic [AW-1:0] b_addr,
  input  logic          b_we,
  input  logic [DW-1:0] b_wd,
  output logic [DW-1:0] b_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wd;
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
  import flash_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SECT_BITS = 3,
  parameter int WIN_CYC   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [7:0]              wdata,
  input  logic [(1<<SECT_BITS)-1:0] prot,
  input  logic                    pg_run,
  input  logic                    er_run,
  input  logic                    er_susp,
  output logic                    prog_go,
  output logic                    susp_go,
  output logic                    resume_go,
  output logic                    erase_go,
  output logic [(1<<SECT_BITS)-1:0] erase_set
);
  localparam int NSECT = 1 << SECT_BITS;
  localparam int UW    = (ADDR_W < 11) ? ADDR_W : 11;
  localparam int WW    = $clog2(WIN_CYC + 1);

  dec_st_t          st_q, st_d;
  logic [NSECT-1:0] col_q, col_d;
  logic [WW-1:0]    win_q;
  logic             win_clr;
  logic             hit1, hit2;
  logic [NSECT-1:0] sec_bit;

  assign hit1    = waddr[UW-1:0] == UNLK_A1[UW-1:0];
  assign hit2    = waddr[UW-1:0] == UNLK_A2[UW-1:0];
  assign sec_bit = NSECT'(1) << waddr[ADDR_W-1 -: SECT_BITS];

  always_comb begin
    st_d      = st_q;
    col_d     = col_q;
    win_clr   = 1'b0;
    prog_go   = 1'b0;
    susp_go   = 1'b0;
    resume_go = 1'b0;
    erase_go  = 1'b0;
    erase_set = col_q;
    if (!wr) begin
      if (st_q == D_COL && win_q == WW'(WIN_CYC - 1)) begin
        erase_go = 1'b1;
        st_d     = D_RD;
      end
    end else if (pg_run) begin
      st_d = st_q;
    end else if (er_run) begin
      susp_go = (wdata == CODE_SUSP);
    end else if (wdata == CODE_RST && st_q != D_PG) begin
      st_d = D_RD;
    end else begin
      case (st_q)
        D_RD: begin
          if (wdata == CODE_UNLK1 && hit1) st_d = D_U1;
          else if (wdata == CODE_SECT && er_susp) resume_go = 1'b1;
        end
        D_U1: st_d = (wdata == CODE_UNLK2 && hit2) ? D_U2 : D_RD;
        D_U2: begin
          if (wdata == CODE_PROG) st_d = D_PG;
          else if (wdata == CODE_ERASE && !er_susp) st_d = D_E1;
          else st_d = D_RD;
        end
        D_PG: begin
          prog_go = 1'b1;
          st_d    = D_RD;
        end
        D_E1: st_d = (wdata == CODE_UNLK1 && hit1) ? D_E2 : D_RD;
        D_E2: st_d = (wdata == CODE_UNLK2 && hit2) ? D_E3 : D_RD;
        D_E3: begin
          if (wdata == CODE_CHIP && hit1) begin
            erase_go  = 1'b1;
            erase_set = ~prot;
            st_d      = D_RD;
          end else if (wdata == CODE_SECT) begin
            col_d   = sec_bit & ~prot;
            win_clr = 1'b1;
            st_d    = D_COL;
          end else begin
            st_d = D_RD;
          end
        end
        D_COL: begin
          if (wdata == CODE_SECT) begin
            col_d   = col_q | (sec_bit & ~prot);
            win_clr = 1'b1;
          end else begin
            erase_go = 1'b1;
            st_d     = D_RD;
          end
        end
        default: st_d = D_RD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= D_RD;
      col_q <= '0;
      win_q <= '0;
    end else begin
      st_q  <= st_d;
      col_q <= col_d;
      if (win_clr) win_q <= '0;
      else if (st_q == D_COL) win_q <= win_q + 1'b1;
    end
  end

  // R13
  busy_ign_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && pg_run) |=> (st_q == $past(st_q)))
    else $error("decoder moved on a write during a program");
endmodule

// File: rtl/flash_algo.sv
module flash_algo
  import flash_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SECT_BITS = 3,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 8,
  parameter int VFY_CYC   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    prog_go,
  input  logic [ADDR_W-1:0]       prog_addr,
  input  logic [7:0]              prog_data,
  input  logic                    erase_go,
  input  logic [(1<<SECT_BITS)-1:0] erase_set,
  input  logic                    susp_go,
  input  logic                    resume_go,
  input  logic [(1<<SECT_BITS)-1:0] prot,
  output logic [ADDR_W-1:0]       b_addr,
  output logic                    b_we,
  output logic [7:0]              b_wd,
  input  logic [7:0]              b_q,
  output logic                    pg_busy,
  output logic [7:0]              pg_data,
  output logic                    er_active,
  output logic                    er_susp,
  output logic [(1<<SECT_BITS)-1:0] er_set
);
  localparam int NSECT = 1 << SECT_BITS;
  localparam int OFS_W = ADDR_W - SECT_BITS;
  localparam int PMAX  = (PROG_CYC > VFY_CYC) ? PROG_CYC : VFY_CYC;
  localparam int PCW   = $clog2(PMAX + 1);
  localparam int ECW   = $clog2(ERASE_CYC + 1);

  algo_st_t             st, sv_st;
  logic [ADDR_W-1:0]    pg_addr;
  logic [7:0]           pg_new;
  logic [PCW-1:0]       pg_cnt;
  logic [ECW-1:0]       er_cnt;
  logic [SECT_BITS-1:0] er_sec, low_sec, pg_sec;
  logic [OFS_W-1:0]     er_ofs;
  logic                 ofs_last, prog_ok;

  assign ofs_last = &er_ofs;
  assign pg_sec   = prog_addr[ADDR_W-1 -: SECT_BITS];
  assign prog_ok  = !prot[pg_sec] && !(er_susp && er_set[pg_sec]);

  always_comb begin
    low_sec = '0;
    for (int i = NSECT - 1; i >= 0; i--)
      if (er_set[i]) low_sec = i[SECT_BITS-1:0];
  end

  always_comb begin
    b_addr = pg_busy ? pg_addr : {er_sec, er_ofs};
    b_we   = 1'b0;
    b_wd   = BYTE_ERASED;
    case (st)
      A_PG_WR: begin
        b_we = 1'b1;
        b_wd = pg_new;
      end
      A_PRE_CHK: begin
        b_we = (b_q != BYTE_ZERO);
        b_wd = BYTE_ZERO;
      end
      A_ER_WR: b_we = 1'b1;
      default: b_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= A_IDLE;
      sv_st     <= A_IDLE;
      pg_busy   <= 1'b0;
      er_active <= 1'b0;
      er_susp   <= 1'b0;
      er_set    <= '0;
      er_sec    <= '0;
      er_ofs    <= '0;
      pg_addr   <= '0;
      pg_data   <= '0;
      pg_new    <= '0;
      pg_cnt    <= '0;
      er_cnt    <= '0;
    end else if (susp_go && er_active && !er_susp && !pg_busy && st != A_IDLE) begin
      er_susp <= 1'b1;
      st      <= A_SUSP;
      sv_st   <= (st == A_PRE_CHK) ? A_PRE_RD : (st == A_EV_CHK) ? A_EV_RD : st;
    end else begin
      case (st)
        A_IDLE, A_SUSP: begin
          if (prog_go && prog_ok) begin
            pg_busy <= 1'b1;
            pg_addr <= prog_addr;
            pg_data <= prog_data;
            st      <= A_PG_RD;
          end else if (st == A_IDLE && erase_go && (|erase_set)) begin
            er_active <= 1'b1;
            er_set    <= erase_set;
            st        <= A_ER_SEL;
          end else if (st == A_SUSP && resume_go) begin
            er_susp <= 1'b0;
            st      <= sv_st;
          end
        end
        A_PG_RD: st <= A_PG_CAP;
        A_PG_CAP: begin
          pg_new <= b_q & pg_data;
          pg_cnt <= PCW'(PROG_CYC - 1);
          st     <= A_PG_WAIT;
        end
        A_PG_WAIT: begin
          if (pg_cnt == '0) st <= A_PG_WR;
          else pg_cnt <= pg_cnt - 1'b1;
        end
        A_PG_WR: st <= A_PG_VRD;
        A_PG_VRD: begin
          pg_cnt <= PCW'(VFY_CYC - 1);
          st     <= A_PG_VCHK;
        end
        A_PG_VCHK: begin
          if (pg_cnt != '0) pg_cnt <= pg_cnt - 1'b1;
          else if (b_q == pg_new) begin
            pg_busy <= 1'b0;
            st      <= er_susp ? A_SUSP : A_IDLE;
          end else st <= A_PG_WR;
        end
        A_ER_SEL: begin
          if (er_set == '0) begin
            er_active <= 1'b0;
            st        <= A_IDLE;
          end else begin
            er_sec <= low_sec;
            er_ofs <= '0;
            st     <= A_PRE_RD;
          end
        end
        A_PRE_RD: st <= A_PRE_CHK;
        A_PRE_CHK: begin
          if (ofs_last) begin
            er_ofs <= '0;
            er_cnt <= ECW'(ERASE_CYC - 1);
            st     <= A_ER_PULSE;
          end else begin
            er_ofs <= er_ofs + 1'b1;
            st     <= A_PRE_RD;
          end
        end
        A_ER_PULSE: begin
          if (er_cnt == '0) begin
            er_ofs <= '0;
            st     <= A_ER_WR;
          end else er_cnt <= er_cnt - 1'b1;
        end
        A_ER_WR: begin
          er_ofs <= er_ofs + 1'b1;
          if (ofs_last) st <= A_EV_RD;
        end
        A_EV_RD: st <= A_EV_CHK;
        A_EV_CHK: begin
          if (b_q != BYTE_ERASED) begin
            er_cnt <= ECW'(ERASE_CYC - 1);
            st     <= A_ER_PULSE;
          end else if (ofs_last) begin
            er_set[er_sec] <= 1'b0;
            st             <= A_ER_SEL;
          end else begin
            er_ofs <= er_ofs + 1'b1;
            st     <= A_EV_RD;
          end
        end
        default: st <= A_IDLE;
      endcase
    end
  end

  // R8
  prot_write_chk: assert property (@(posedge clk) disable iff (rst)
    b_we |-> !prot[b_addr[ADDR_W-1 -: SECT_BITS]])
    else $error("write into a protected sector");

  // R11
  susp_write_chk: assert property (@(posedge clk) disable iff (rst)
    (b_we && er_susp) |-> !er_set[b_addr[ADDR_W-1 -: SECT_BITS]])
    else $error("write into the erase set while suspended");

  // R12
  susp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (er_susp && $past(er_susp)) |-> ($stable(er_set) && $stable(er_sec) && $stable(er_ofs)))
    else $error("erase progress moved while suspended");

  // R6
  er_data_chk: assert property (@(posedge clk) disable iff (rst)
    (b_we && !pg_busy) |-> (b_wd == BYTE_ERASED || b_wd == BYTE_ZERO))
    else $error("erase wrote a byte other than 00 or FF");
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SECT_BITS = 3,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 8,
  parameter int VFY_CYC   = 2,
  parameter int WIN_CYC   = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ce_n,
  input  logic                      we_n,
  input  logic                      oe_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [7:0]                wdata,
  output logic [7:0]                rdata,
  input  logic [(1<<SECT_BITS)-1:0] sect_prot
);
  localparam int NSECT = 1 << SECT_BITS;

  logic              wr_cyc, rd_cyc;
  logic              prog_go, susp_go, resume_go, erase_go;
  logic [NSECT-1:0]  erase_set, er_set;
  logic [ADDR_W-1:0] b_addr;
  logic              b_we;
  logic [7:0]        b_wd, b_q, a_q;
  logic              pg_busy, er_active, er_susp, er_run, insec;
  logic [7:0]        pg_data;
  logic              tog6_q, tog2_q, rsel_q;
  logic [7:0]        stat_q;

  assign wr_cyc = !ce_n && !we_n;
  assign rd_cyc = !ce_n && !oe_n && we_n;
  assign er_run = er_active && !er_susp;
  assign insec  = er_active && er_set[addr[ADDR_W-1 -: SECT_BITS]];

  flash_cmd_dec #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .WIN_CYC(WIN_CYC)) u_dec (
    .clk(clk), .rst(rst), .wr(wr_cyc), .waddr(addr), .wdata(wdata), .prot(sect_prot),
    .pg_run(pg_busy), .er_run(er_run), .er_susp(er_susp),
    .prog_go(prog_go), .susp_go(susp_go), .resume_go(resume_go),
    .erase_go(erase_go), .erase_set(erase_set)
  );

  flash_algo #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .PROG_CYC(PROG_CYC),
               .ERASE_CYC(ERASE_CYC), .VFY_CYC(VFY_CYC)) u_algo (
    .clk(clk), .rst(rst), .prog_go(prog_go), .prog_addr(addr), .prog_data(wdata),
    .erase_go(erase_go), .erase_set(erase_set), .susp_go(susp_go), .resume_go(resume_go),
    .prot(sect_prot), .b_addr(b_addr), .b_we(b_we), .b_wd(b_wd), .b_q(b_q),
    .pg_busy(pg_busy), .pg_data(pg_data), .er_active(er_active), .er_susp(er_susp),
    .er_set(er_set)
  );

  flash_array #(.AW(ADDR_W), .DW(8)) u_mem (
    .clk(clk), .a_addr(addr), .a_q(a_q),
    .b_addr(b_addr), .b_we(b_we), .b_wd(b_wd), .b_q(b_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tog6_q <= 1'b0;
      tog2_q <= 1'b0;
      rsel_q <= 1'b0;
      stat_q <= '0;
    end else if (rd_cyc) begin
      rsel_q <= pg_busy || er_run || (er_susp && insec);
      if (pg_busy)     stat_q <= {~pg_data[7], tog6_q, 3'b000, tog2_q, 2'b00};
      else if (er_run) stat_q <= {1'b0, tog6_q, 3'b000, tog2_q, 2'b00};
      else             stat_q <= {1'b1, 1'b0, 3'b000, tog2_q, 2'b00};
      tog6_q <= tog6_q ^ (pg_busy || er_run);
      tog2_q <= tog2_q ^ insec;
    end
  end

  assign rdata = rsel_q ? stat_q : a_q;

  // R5
  tog_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_cyc |=> $stable(tog6_q))
    else $error("toggle bit moved without a read");
endmodule

// File: tb/tb_flash_ctrl.sv
module tb_flash_ctrl;
  localparam int ADDR_W = 8;
  localparam int SECT_BITS = 3;
  localparam int WIN_CYC = 16;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] sect_prot = '0;
  logic [7:0] exp_mem [DEPTH];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_ctrl #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .WIN_CYC(WIN_CYC)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .sect_prot(sect_prot)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    ce_n = 1'b0; oe_n = 1'b0; addr = a;
    @(posedge clk); @(negedge clk);
    d = rdata;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic unlock();
    wr(8'h55, 8'hAA);
    wr(8'hAA, 8'h55);
  endtask

  task automatic prog(input logic [7:0] a, input logic [7:0] d);
    unlock();
    wr(8'h55, 8'hA0);
    wr(a, d);
  endtask

  task automatic erase_open();
    unlock();
    wr(8'h55, 8'h80);
    unlock();
  endtask

  task automatic wait_done(input logic [7:0] a, input string tag);
    logic [7:0] r1, r2;
    bit done = 1'b0;
    for (int i = 0; i < 4000 && !done; i++) begin
      rd(a, r1);
      rd(a, r2);
      done = (r1[6] == r2[6]);
    end
    if (!done) check(1'b0, {tag, " completion"}, 0, 1);
  endtask

  task automatic sweep(input string tag);
    logic [7:0] v;
    int bad = 0;
    int first_a = 0, first_v = 0, first_e = 0;
    for (int i = 0; i < DEPTH; i++) begin
      rd(i[7:0], v);
      if (v !== exp_mem[i]) begin
        if (bad == 0) begin first_a = i; first_v = v; first_e = exp_mem[i]; end
        bad++;
      end
    end
    if (bad != 0) $display("  sweep %s: %0d mismatches, first at %0h", tag, bad, first_a);
    check(bad == 0, {tag, " array sweep"}, first_v, first_e);
  endtask

  task automatic model_prog(input logic [7:0] a, input logic [7:0] d);
    exp_mem[a] = exp_mem[a] & d;
  endtask

  task automatic model_erase(input int s);
    for (int i = 0; i < 32; i++) exp_mem[s*32 + i] = 8'hFF;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r1, r2, r3, r4;
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    sweep("R1");

    // R2 / R4 / R5: program with polling
    prog(8'h23, 8'h5A);
    rd(8'h23, r1);
    rd(8'h23, r2);
    check(r1[7] == 1'b1, "R4 poll bit7", r1[7], 1);
    check(r1[6] != r2[6], "R5 toggle while programming", r2[6], ~r1[6]);
    wait_done(8'h23, "R2");
    model_prog(8'h23, 8'h5A);
    rd(8'h23, r1);
    check(r1 == 8'h5A, "R4 data after program", r1, 8'h5A);
    rd(8'h23, r2);
    check(r1 == r2, "R5 stable when idle", r2, r1);
    prog(8'h23, 8'hF0);
    wait_done(8'h23, "R2");
    model_prog(8'h23, 8'hF0);
    rd(8'h23, r1);
    check(r1 == 8'h50, "R2 bits only clear", r1, 8'h50);
    prog(8'hA3, 8'h81);
    rd(8'hA3, r1);
    check(r1[7] == 1'b0, "R4 poll bit7 complement", r1[7], 0);
    wait_done(8'hA3, "R2");
    model_prog(8'hA3, 8'h81);
    prog(8'h45, 8'h12); wait_done(8'h45, "R2"); model_prog(8'h45, 8'h12);
    prog(8'h67, 8'h34); wait_done(8'h67, "R2"); model_prog(8'h67, 8'h34);
    prog(8'hC9, 8'h77); wait_done(8'hC9, "R2"); model_prog(8'hC9, 8'h77);
    prog(8'h2F, 8'h3C); wait_done(8'h2F, "R2"); model_prog(8'h2F, 8'h3C);
    prog(8'hE0, 8'h99); wait_done(8'hE0, "R2"); model_prog(8'hE0, 8'h99);
    sweep("R2");

    // R3: broken sequence and reset code
    wr(8'h55, 8'hAA);
    wr(8'h10, 8'h55);
    wr(8'h55, 8'hA0);
    wr(8'h23, 8'h00);
    idle(20);
    rd(8'h23, r1);
    check(r1 == 8'h50, "R3 bad unlock ignored", r1, 8'h50);
    unlock();
    wr(8'h00, 8'hF0);
    wr(8'h55, 8'hA0);
    wr(8'h23, 8'h00);
    idle(20);
    rd(8'h23, r1);
    check(r1 == 8'h50, "R3 reset code aborts", r1, 8'h50);

    // R8: protected sector program
    sect_prot = 8'b0010_0000;
    prog(8'hA3, 8'h00);
    idle(20);
    rd(8'hA3, r1);
    check(r1 == 8'h81, "R8 protected program ignored", r1, 8'h81);

    // R6 / R9 / R13: multi-sector erase of 1 and 3, 5 protected
    erase_open();
    wr(8'h20, 8'h30);
    wr(8'h60, 8'h30);
    wr(8'hA0, 8'h30);
    idle(WIN_CYC + 4);
    rd(8'h2F, r1);
    rd(8'h2F, r2);
    check(r1[7] == 1'b0, "R9 erase bit7", r1[7], 0);
    check(r1[2] != r2[2], "R9 bit2 toggles in set", r2[2], ~r1[2]);
    rd(8'h45, r3);
    rd(8'h45, r4);
    check(r3[2] == r4[2], "R9 bit2 stable outside set", r4[2], r3[2]);
    check(r3[6] != r4[6], "R5 toggle while erasing", r4[6], ~r3[6]);
    prog(8'hE0, 8'h00);
    wait_done(8'h45, "R6");
    model_erase(1);
    model_erase(3);
    sweep("R6 R8 R13");

    // R10 / R11 / R12: suspend and resume
    prog(8'h40, 8'h11); wait_done(8'h40, "R11"); model_prog(8'h40, 8'h11);
    erase_open();
    wr(8'h40, 8'h30);
    idle(WIN_CYC + 6);
    wr(8'h00, 8'hB0);
    idle(2);
    rd(8'hC9, r1);
    check(r1 == 8'h77, "R10 read outside set", r1, 8'h77);
    rd(8'h45, r1);
    rd(8'h45, r2);
    check(r1[7] == 1'b1, "R10 suspended bit7", r1[7], 1);
    check(r1[2] != r2[2], "R10 bit2 toggles in set", r2[2], ~r1[2]);
    check(r1[6] == r2[6], "R10 bit6 stable", r2[6], r1[6]);
    prog(8'h85, 8'h5A);
    wait_done(8'h85, "R11");
    model_prog(8'h85, 8'h5A);
    rd(8'h85, r1);
    check(r1 == 8'h5A, "R11 program while suspended", r1, 8'h5A);
    prog(8'h41, 8'h00);
    rd(8'h85, r1);
    rd(8'h85, r2);
    check(r1 == 8'h5A && r2 == 8'h5A, "R11 program into set ignored", r2, 8'h5A);
    wr(8'h00, 8'h30);
    wait_done(8'hC9, "R12");
    model_erase(2);
    sweep("R12");

    // R7: chip erase with sector 5 protected
    erase_open();
    wr(8'h55, 8'h10);
    rd(8'h00, r1);
    rd(8'h00, r2);
    check(r1[6] != r2[6], "R7 chip erase busy", r2[6], ~r1[6]);
    wait_done(8'h00, "R7");
    for (int s = 0; s < 8; s++) if (s != 5) model_erase(s);
    sweep("R7 R8");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule